// File: doc/BRIEF.md
# Dual-Set Baud Clock Selector

This block produces the bit-clock enables for the receive and transmit halves of one asynchronous serial channel. It runs from a single fixed reference clock and emits single-cycle tick pulses on `rx_tick` and `tx_tick`. A shifter downstream consumes these ticks, and the shifter is not part of this block.

A select byte holds one 4-bit code for each direction. A separate set bit chooses which of two rate tables applies to both codes. Thirteen codes in each table drive an internal divider. The remaining three codes take the clock from elsewhere: one passes a timer tick through, and two take a dedicated external clock pin for that direction, used either as a 16x or a 1x clock. For each direction a flag reports whether its tick is a 16x oversampling clock or a 1x bit clock.

All internal rates follow the reference frequency in direct proportion. The divider ratio is the rounded value of REF_HZ / (16 × baud).

Top module: `baudsel_top`

## Requirements
- R1: The receive code is bits [7:4] of the select byte and the transmit code is bits [3:0]. Each direction runs from its own code only.
- R2: With the set bit at 0, codes 0–12 give 50, 110, 134.5, 200, 300, 600, 1200, 1050, 2400, 4800, 7200, 9600 and 38400 baud.
- R3: With the set bit at 1, codes 0–12 give 75, 110, 134.5, 150, 300, 600, 1200, 2000, 2400, 4800, 1800, 9600 and 19200 baud.
- R4: An internal rate gives one-cycle tick pulses spaced exactly D cycles apart, where D = round(REF_HZ / (16 × baud)). For example, D = 24 at 9600 baud with the default reference.
- R5: Code 13 passes `timer_tick` to the direction's tick with one cycle of latency, in both sets.
- R6: Code 14 uses the direction's own external pin (`rx_ext_clk` or `tx_ext_clk`) as a 16x clock. Each rising edge of the pin gives exactly one tick pulse, visible after the third clock edge that follows the pin change. The pin of the other direction has no effect.
- R7: Code 15 uses the same pin in the same way as a 1x clock. The 16x flag is 0 for code 15 and 1 for every other code.
- R8: A write to the select byte or to the set bit reloads the divider. The edge that takes the write produces no tick. For an internal code, the first tick appears exactly D cycles after that edge, whatever the count was before the write.
- R9: After reset the select byte is 0 and the set bit is 0. Both ticks are low and both 16x flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_we | input | 1 | Write strobe for the select byte |
| sel_wdata | input | 8 | Select byte: receive code [7:4], transmit code [3:0] |
| set_we | input | 1 | Write strobe for the set bit |
| set_wdata | input | 1 | Rate table choice |
| timer_tick | input | 1 | Pulse from the counter/timer, used by code 13 |
| rx_ext_clk | input | 1 | External receive clock pin, asynchronous |
| tx_ext_clk | input | 1 | External transmit clock pin, asynchronous |
| rx_tick | output | 1 | Receive bit-clock enable pulse |
| rx_is_16x | output | 1 | High when rx_tick is a 16x clock |
| tx_tick | output | 1 | Transmit bit-clock enable pulse |
| tx_is_16x | output | 1 | High when tx_tick is a 16x clock |

## Verification
The bench builds the block with its default parameters: a 3,686,400 Hz reference and a 16-bit divider. All 26 table dividers, from 6 up to 4608, therefore fit within the run. For every internal code in both sets, the bench measures both the reload-to-first-tick delay and the following period. It checks these against dividers that it computes in floating point from the baud tables. Pulse trains on each external pin, sent with both directions selected, show that each pin drives only its own direction and that the 1x flag tracks code 15.

// File: rtl/baudsel_pkg.sv
package baudsel_pkg;

    localparam int CODE_W     = 4;
    localparam int NUM_RATES  = 13;
    localparam int NUM_DIVS   = 2 * NUM_RATES;
    localparam int CODE_TIMER = 13;
    localparam int CODE_EXT16 = 14;
    localparam int CODE_EXT1  = 15;

    // Baud rate in tenths of a baud, per table and code.
    function automatic longint rate_x10(input bit alt_set, input int code);
        longint r;
        case (code)
            0:       r = alt_set ? 750    : 500;
            1:       r = 1100;
            2:       r = 1345;
            3:       r = alt_set ? 1500   : 2000;
            4:       r = 3000;
            5:       r = 6000;
            6:       r = 12000;
            7:       r = alt_set ? 20000  : 10500;
            8:       r = 24000;
            9:       r = 48000;
            10:      r = alt_set ? 18000  : 72000;
            11:      r = 96000;
            default: r = alt_set ? 192000 : 384000;
        endcase
        return r;
    endfunction

    // Rounded divider for table entry idx (0..12 first set, 13..25 second set).
    function automatic longint calc_div(input longint ref_hz, input int idx);
        longint r;
        r = rate_x10(idx >= NUM_RATES, idx % NUM_RATES);
        return (ref_hz * 10 + 8 * r) / (16 * r);
    endfunction

endpackage

// File: rtl/baudsel_div.sv
module baudsel_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (reload) begin
            st_d.cnt = div_val - DIV_W'(1);
        end else if (st_q.cnt == '0) begin
            st_d.cnt  = div_val - DIV_W'(1);
            st_d.tick = run;
        end else begin
            st_d.cnt = st_q.cnt - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '1;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

    AST_TICK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |=> !st_q.tick); // R4
    AST_RELOAD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !tick); // R8

endmodule

// File: rtl/baudsel_rise.sv
module baudsel_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic rise;
    } rise_state_t;

    rise_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        st_d.rise = st_q.s2 & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = st_q.rise;

    AST_EDGE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rise |=> !st_q.rise); // R6

endmodule

// File: rtl/baudsel_path.sv
module baudsel_path
    import baudsel_pkg::*;
#(
    parameter longint REF_HZ = 3686400,
    parameter int     DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_q,
    input  logic [CODE_W-1:0] code_d,
    input  logic              set_d,
    input  logic              reload,
    input  logic              timer_tick,
    input  logic              ext_clk,
    output logic              tick,
    output logic              is_16x
);

    localparam int IDX_W = $clog2(NUM_DIVS);

    typedef struct packed {
        logic timer;
    } path_state_t;

    path_state_t st_d, st_q;

    logic [DIV_W-1:0] div_tab [NUM_DIVS];
    logic [IDX_W-1:0] idx;
    logic [DIV_W-1:0] div_val;
    logic             div_tick;
    logic             ext_rise;
    logic             run;

    for (genvar g = 0; g < NUM_DIVS; g++) begin : g_tab
        assign div_tab[g] = DIV_W'(calc_div(REF_HZ, g));
    end

    always_comb begin
        if (int'(code_d) >= NUM_RATES) begin
            idx = '0;
        end else if (set_d) begin
            idx = IDX_W'(code_d) + IDX_W'(NUM_RATES);
        end else begin
            idx = IDX_W'(code_d);
        end
        div_val = div_tab[idx];
    end

    assign run = (int'(code_q) < NUM_RATES);

    always_comb begin
        st_d       = st_q;
        st_d.timer = timer_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    baudsel_div #(.DIV_W(DIV_W)) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .reload  (reload),
        .div_val (div_val),
        .tick    (div_tick)
    );

    baudsel_rise rise_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_clk),
        .rise  (ext_rise)
    );

    always_comb begin
        case (int'(code_q))
            CODE_TIMER:            tick = st_q.timer;
            CODE_EXT16, CODE_EXT1: tick = ext_rise;
            default:               tick = div_tick;
        endcase
    end

    assign is_16x = (int'(code_q) != CODE_EXT1);

    AST_TIMER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(code_q) == CODE_TIMER && $past(timer_tick)) |-> tick); // R5

endmodule

// File: rtl/baudsel_top.sv
module baudsel_top
    import baudsel_pkg::*;
#(
    parameter longint REF_HZ = 3686400,
    parameter int     DIV_W  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_we,
    input  logic [7:0] sel_wdata,
    input  logic       set_we,
    input  logic       set_wdata,
    input  logic       timer_tick,
    input  logic       rx_ext_clk,
    input  logic       tx_ext_clk,
    output logic       rx_tick,
    output logic       rx_is_16x,
    output logic       tx_tick,
    output logic       tx_is_16x
);

    localparam int NUM_DIR = 2;  // 0 = receive, 1 = transmit

    typedef struct packed {
        logic [CODE_W-1:0] rx_code;
        logic [CODE_W-1:0] tx_code;
        logic              alt_set;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic reload;

    always_comb begin
        cfg_d = cfg_q;
        if (sel_we) begin
            cfg_d.rx_code = sel_wdata[7:4];
            cfg_d.tx_code = sel_wdata[3:0];
        end
        if (set_we) begin
            cfg_d.alt_set = set_wdata;
        end
    end

    assign reload = sel_we | set_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    logic [CODE_W-1:0] code_q_a [NUM_DIR];
    logic [CODE_W-1:0] code_d_a [NUM_DIR];
    logic              ext_a    [NUM_DIR];
    logic              tick_a   [NUM_DIR];
    logic              x16_a    [NUM_DIR];

    assign code_q_a[0] = cfg_q.rx_code;
    assign code_q_a[1] = cfg_q.tx_code;
    assign code_d_a[0] = cfg_d.rx_code;
    assign code_d_a[1] = cfg_d.tx_code;
    assign ext_a[0]    = rx_ext_clk;
    assign ext_a[1]    = tx_ext_clk;

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        baudsel_path #(.REF_HZ(REF_HZ), .DIV_W(DIV_W)) path_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .code_q     (code_q_a[g]),
            .code_d     (code_d_a[g]),
            .set_d      (cfg_d.alt_set),
            .reload     (reload),
            .timer_tick (timer_tick),
            .ext_clk    (ext_a[g]),
            .tick       (tick_a[g]),
            .is_16x     (x16_a[g])
        );
    end

    assign rx_tick   = tick_a[0];
    assign tx_tick   = tick_a[1];
    assign rx_is_16x = x16_a[0];
    assign tx_is_16x = x16_a[1];

    AST_1X_ONLY_TOP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_we) && $past(sel_wdata[7:4]) != 4'hF |-> rx_is_16x); // R7

endmodule

// File: tb/baudsel_top_tb_top.sv
module baudsel_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_we = 1'b0;
    logic [7:0] sel_wdata = '0;
    logic       set_we = 1'b0;
    logic       set_wdata = 1'b0;
    logic       timer_tick = 1'b0;
    logic       rx_ext_clk = 1'b0;
    logic       tx_ext_clk = 1'b0;
    logic       rx_tick, rx_is_16x, tx_tick, tx_is_16x;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    baudsel_top dut_i (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .set_we(set_we), .set_wdata(set_wdata), .timer_tick(timer_tick),
        .rx_ext_clk(rx_ext_clk), .tx_ext_clk(tx_ext_clk),
        .rx_tick(rx_tick), .rx_is_16x(rx_is_16x),
        .tx_tick(tx_tick), .tx_is_16x(tx_is_16x)
    );

    function automatic real baud_of(input int s, input int c);
        real t0 [13] = '{50.0, 110.0, 134.5, 200.0, 300.0, 600.0, 1200.0,
                          1050.0, 2400.0, 4800.0, 7200.0, 9600.0, 38400.0};
        real t1 [13] = '{75.0, 110.0, 134.5, 150.0, 300.0, 600.0, 1200.0,
                          2000.0, 2400.0, 4800.0, 1800.0, 9600.0, 19200.0};
        return (s != 0) ? t1[c] : t0[c];
    endfunction

    function automatic int exp_div(input int s, input int c);
        return $rtoi(3686400.0 / (16.0 * baud_of(s, c)) + 0.5);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_sel(input logic [7:0] v);
        @(negedge clk);
        sel_we = 1'b1; sel_wdata = v;
        @(posedge clk);
        #1 sel_we = 1'b0;
    endtask

    task automatic write_set(input logic v);
        @(negedge clk);
        set_we = 1'b1; set_wdata = v;
        @(posedge clk);
        #1 set_we = 1'b0;
    endtask

    // Counts negedges until the chosen tick is seen high.
    task automatic wait_tick(input bit tx, output int n, output bit mismatch);
        n = 0; mismatch = 1'b0;
        do begin
            @(negedge clk);
            n++;
            if (rx_tick !== tx_tick) mismatch = 1'b1;
        end while (!(tx ? tx_tick : rx_tick) && n < 10000);
    endtask

    task automatic pulse_pins(input bit use_tx, output int rx_cnt, output int tx_cnt);
        rx_cnt = 0; tx_cnt = 0;
        for (int p = 0; p < 5; p++) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (rx_tick) rx_cnt++;
                if (tx_tick) tx_cnt++;
                if (use_tx) tx_ext_clk = (k < 4);
                else        rx_ext_clk = (k < 4);
            end
        end
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (rx_tick) rx_cnt++;
            if (tx_tick) tx_cnt++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int n, n2, d, rc, tc;
        bit mm;

        // R9 reset state
        repeat (3) @(negedge clk);
        check(rx_tick == 0 && tx_tick == 0, "R9 ticks low in reset", int'(rx_tick | tx_tick), 0);
        check(rx_is_16x && tx_is_16x, "R9 16x flags high in reset", int'(rx_is_16x & tx_is_16x), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_tick == 0 && tx_tick == 0, "R9 ticks low after reset", int'(rx_tick | tx_tick), 0);
        check(rx_is_16x && tx_is_16x, "R9 flags high after reset", int'(rx_is_16x & tx_is_16x), 1);

        // R2 / R3 / R4 / R8 full sweep of internal codes in both sets
        for (int s = 0; s < 2; s++) begin
            write_set(s[0]);
            for (int c = 0; c < 13; c++) begin
                d = exp_div(s, c);
                write_sel({c[3:0], c[3:0]});
                wait_tick(1'b0, n, mm);
                check(n == d + 1, s == 0 ? "R2/R8 first tick delay" : "R3/R8 first tick delay", n, d + 1);
                check(!mm, "R1 rx and tx tick together on equal codes", int'(mm), 0);
                wait_tick(1'b0, n2, mm);
                check(n2 == d, s == 0 ? "R2/R4 tick period" : "R3/R4 tick period", n2, d);
                @(negedge clk);
                check(!rx_tick, "R4 tick lasts one cycle", int'(rx_tick), 0);
                check(rx_is_16x && tx_is_16x, "R7 16x flag for internal code", int'(rx_is_16x), 1);
            end
        end

        // R1 separate fields
        write_set(1'b0);
        write_sel(8'hCB);
        wait_tick(1'b0, n, mm);
        check(n == 6 + 1, "R1 rx code from upper nibble", n, 7);
        write_sel(8'hCB);
        wait_tick(1'b1, n, mm);
        check(n == 24 + 1, "R1 tx code from lower nibble", n, 25);

        // R8 rewrite in mid-count
        write_sel(8'h00);
        repeat (100) @(negedge clk);
        write_sel(8'hBB);
        wait_tick(1'b0, n, mm);
        check(n == 25, "R8 rewrite restarts count", n, 25);

        // R8 set-bit write reloads too
        write_sel(8'hCC);
        repeat (3) @(negedge clk);
        write_set(1'b1);
        wait_tick(1'b0, n, mm);
        check(n == 13, "R8 set write reloads divider", n, 13);

        // R5 timer pass-through, both sets
        for (int s = 0; s < 2; s++) begin
            write_set(s[0]);
            write_sel(8'hDD);
            repeat (2) @(negedge clk);
            check(!rx_tick && !tx_tick, "R5 idle timer gives no tick", int'(rx_tick | tx_tick), 0);
            timer_tick = 1'b1;
            @(negedge clk);
            timer_tick = 1'b0;
            check(rx_tick && tx_tick, "R5 tick one cycle after timer", int'(rx_tick & tx_tick), 1);
            @(negedge clk);
            check(!rx_tick && !tx_tick, "R5 timer tick one cycle wide", int'(rx_tick | tx_tick), 0);
        end

        // R6 external 16x pins, latency then pin isolation
        write_sel(8'hEE);
        @(negedge clk);
        rx_ext_clk = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!rx_tick && n < 20);
        check(n == 3, "R6 pin edge latency", n, 3);
        rx_ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        pulse_pins(1'b0, rc, tc);
        check(rc == 5, "R6 rx pin edges to rx ticks", rc, 5);
        check(tc == 0, "R6 rx pin has no effect on tx", tc, 0);
        pulse_pins(1'b1, rc, tc);
        check(tc == 5, "R6 tx pin edges to tx ticks", tc, 5);
        check(rc == 0, "R6 tx pin has no effect on rx", rc, 0);
        check(rx_is_16x && tx_is_16x, "R6 code 14 is 16x", int'(rx_is_16x & tx_is_16x), 1);

        // R7 external 1x
        write_sel(8'hFF);
        @(negedge clk);
        check(!rx_is_16x && !tx_is_16x, "R7 code 15 is 1x", int'(rx_is_16x | tx_is_16x), 0);
        pulse_pins(1'b0, rc, tc);
        check(rc == 5 && tc == 0, "R7 rx pin 1x ticks", rc, 5);
        pulse_pins(1'b1, rc, tc);
        check(tc == 5 && rc == 0, "R7 tx pin 1x ticks", tc, 5);
        write_sel(8'hF0);
        @(negedge clk);
        check(!rx_is_16x && tx_is_16x, "R7 flag per direction", int'(tx_is_16x), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule